// File: doc/BRIEF.md
# Scoreboard Out-of-Order Controller

This block is the central hazard tracker for a processor core that issues instructions in program order but lets them execute and retire out of order. It serves four fixed-latency execution units: an integer/load unit, a floating-point adder, a multiplier and a divider. For each unit it keeps an entry with the destination, the two source registers, the producing unit of each source and a ready flag per source. For each architectural register it records which unit will write it next. Operand values, memory and branches live elsewhere. The block only decides in which cycle each instruction may take its next step.

An in-order queue presents one instruction per cycle with a valid flag, a unit selector and three register indices. The controller accepts the instruction when its unit is free and no in-flight instruction targets the same destination. Each accepted instruction gets a sequence tag. The block then reports, per unit and per cycle, strobes for operand read, execution complete and result write. The tag of the instruction held in each unit comes out on a shared bus. The strobes are combinational from the current state, so an event is visible in the cycle in which it happens.

Top module: `scoreboard_ctrl`

## Requirements
- R1: Instructions are accepted strictly in queue order, at most one per cycle. `iss_fire` is high in the accepting cycle, and `iss_tag` increments by one after each acceptance.
- R2: A unit stays occupied from its issue cycle through its write cycle. A following instruction for the same unit is accepted at the earliest in the cycle after that write.
- R3: An instruction is not accepted while another in-flight instruction has the same destination register. It may be accepted in the cycle after that instruction writes.
- R4: Operand read happens at the earliest in the cycle after issue. It also happens no earlier than the cycle after the last producer of each source writes its result. A producer writing in the issue cycle counts as already written.
- R5: Execution complete is signalled exactly LAT cycles after operand read. The defaults are 1 for the integer/load unit, 2 for the adder, 10 for the multiplier and 40 for the divider.
- R6: The result write happens at the earliest in the cycle after execution complete.
- R7: A result write is held while any other unit that has not yet read its operands still needs the old value of that destination register. The write then happens in the cycle after that read.
- R8: After reset no unit is occupied, no read, complete or write strobe is high, `in_ready` is high and `iss_tag` is 0.
- R9: `in_op` selects the unit: 0 integer/load, 1 adder, 2 multiplier, 3 divider. The strobe vectors use the same bit order, and tag field u of `fu_tag` is bits [u*TW +: TW].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Queue head holds an instruction |
| in_op | input | 2 | Target unit of the queue head |
| in_dst | input | $clog2(NREG) | Destination register |
| in_src1 | input | $clog2(NREG) | First source register |
| in_src2 | input | $clog2(NREG) | Second source register |
| in_ready | output | 1 | Queue head can be accepted this cycle |
| iss_fire | output | 1 | Issue strobe |
| iss_tag | output | TW | Tag given to the issuing instruction |
| rd_fire | output | 4 | Per-unit operand-read strobe |
| ex_fire | output | 4 | Per-unit execution-complete strobe |
| wr_fire | output | 4 | Per-unit result-write strobe |
| fu_tag | output | 4*TW | Tag of the instruction held by each unit |

## Verification
The bench builds the block with its default parameters: 32 registers, 6-bit tags and latencies of 1, 2, 10 and 40. With these values a six-instruction load/multiply/subtract/divide/add sequence reproduces a full scoreboard timing chart. That chart includes a structural stall on the load unit, operand waits behind both loads and the multiplier, and an adder write held for many cycles behind the slow divider's operand read. A second directed program after a fresh reset reaches a destination-register stall and a back-to-back load that waits on both its unit and its source register.

// File: rtl/scoreboard_ctrl.sv
`timescale 1ns/1ps
module scoreboard_ctrl #(
  parameter int NREG    = 32,
  parameter int TW      = 6,
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [1:0]                in_op,
  input  logic [$clog2(NREG)-1:0]   in_dst,
  input  logic [$clog2(NREG)-1:0]   in_src1,
  input  logic [$clog2(NREG)-1:0]   in_src2,
  output logic                      in_ready,
  output logic                      iss_fire,
  output logic [TW-1:0]             iss_tag,
  output logic [3:0]                rd_fire,
  output logic [3:0]                ex_fire,
  output logic [3:0]                wr_fire,
  output logic [4*TW-1:0]           fu_tag
);
  localparam int NFU = 4;
  localparam int RW  = $clog2(NREG);
  localparam int CW  = $clog2(LAT_INT + LAT_ADD + LAT_MUL + LAT_DIV + 1);

  logic [NFU-1:0] busy, rdone, exdone, rj, rk, war;
  logic [RW-1:0]  fi [NFU];
  logic [RW-1:0]  fj [NFU];
  logic [RW-1:0]  fk [NFU];
  logic [1:0]     qj [NFU];
  logic [1:0]     qk [NFU];
  logic [CW-1:0]  cnt [NFU];
  logic [TW-1:0]  tg [NFU];
  logic [NREG-1:0] rs_v;
  logic [1:0]     rs_q [NREG];
  logic [TW-1:0]  tag_ctr;
  logic           j_rdy, k_rdy;

  function automatic logic [CW-1:0] lat_m1(input int u);
    case (u)
      0:       return CW'(LAT_INT - 1);
      1:       return CW'(LAT_ADD - 1);
      2:       return CW'(LAT_MUL - 1);
      default: return CW'(LAT_DIV - 1);
    endcase
  endfunction

  always_comb begin
    for (int u = 0; u < NFU; u++) begin
      war[u] = 1'b0;
      for (int v = 0; v < NFU; v++)
        if (v != u && busy[v] &&
            ((rj[v] && fj[v] == fi[u]) || (rk[v] && fk[v] == fi[u])))
          war[u] = 1'b1;
    end
  end

  assign rd_fire  = busy & ~rdone & rj & rk;
  assign wr_fire  = busy & exdone & ~war;
  assign in_ready = ~busy[in_op] & ~rs_v[in_dst];
  assign iss_fire = in_valid & in_ready;
  assign iss_tag  = tag_ctr;
  assign j_rdy    = ~rs_v[in_src1] | wr_fire[rs_q[in_src1]];
  assign k_rdy    = ~rs_v[in_src2] | wr_fire[rs_q[in_src2]];

  for (genvar u = 0; u < NFU; u++) begin : g_out
    assign ex_fire[u] = busy[u] & rdone[u] & ~exdone[u] & (cnt[u] == '0);
    assign fu_tag[u*TW +: TW] = tg[u];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0; rdone <= '0; exdone <= '0; rj <= '0; rk <= '0;
      rs_v <= '0; tag_ctr <= '0;
      for (int u = 0; u < NFU; u++) begin
        fi[u] <= '0; fj[u] <= '0; fk[u] <= '0; qj[u] <= '0; qk[u] <= '0;
        cnt[u] <= '0; tg[u] <= '0;
      end
      for (int r = 0; r < NREG; r++) rs_q[r] <= '0;
    end else begin
      for (int u = 0; u < NFU; u++) begin
        if (wr_fire[u]) begin
          busy[u] <= 1'b0;
          rs_v[fi[u]] <= 1'b0;
          for (int g = 0; g < NFU; g++)
            if (busy[g] && !rdone[g]) begin
              if (!rj[g] && qj[g] == 2'(u)) rj[g] <= 1'b1;
              if (!rk[g] && qk[g] == 2'(u)) rk[g] <= 1'b1;
            end
        end
        if (rd_fire[u]) begin
          rdone[u] <= 1'b1;
          rj[u] <= 1'b0;
          rk[u] <= 1'b0;
          cnt[u] <= lat_m1(u);
        end else if (busy[u] && rdone[u] && !exdone[u]) begin
          if (cnt[u] == '0) exdone[u] <= 1'b1;
          else cnt[u] <= cnt[u] - 1'b1;
        end
      end
      if (iss_fire) begin
        busy[in_op]   <= 1'b1;
        rdone[in_op]  <= 1'b0;
        exdone[in_op] <= 1'b0;
        fi[in_op] <= in_dst;
        fj[in_op] <= in_src1;
        fk[in_op] <= in_src2;
        qj[in_op] <= rs_q[in_src1];
        qk[in_op] <= rs_q[in_src2];
        rj[in_op] <= j_rdy;
        rk[in_op] <= k_rdy;
        tg[in_op] <= tag_ctr;
        rs_v[in_dst] <= 1'b1;
        rs_q[in_dst] <= in_op;
        tag_ctr <= tag_ctr + 1'b1;
      end
    end
  end

  a_r1_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> iss_tag == TW'($past(iss_tag) + 1'b1));

  a_r2_unit_held: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> !(iss_fire && in_op == $past(in_op)));

  for (genvar u = 0; u < NFU; u++) begin : g_chk
    a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire[u] |=> !rd_fire[u]);
    a_r5_single_done: assert property (@(posedge clk) disable iff (!rst_n)
      ex_fire[u] |=> !ex_fire[u]);
    a_r6_no_wr_with_ex: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire[u] |-> !ex_fire[u]);
    for (genvar v = 0; v < NFU; v++) begin : g_pair
      if (v > u) begin : g_waw
        a_r3_waw_distinct: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_fire[u] && wr_fire[v]) |-> fi[u] != fi[v]);
      end
      if (v != u) begin : g_war
        a_r7_war_order: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_fire[u] && rd_fire[v]) |-> (fj[v] != fi[u] && fk[v] != fi[u]));
      end
    end
  end
endmodule

// File: tb/test_scoreboard_ctrl.sv
`timescale 1ns/1ps
module test_scoreboard_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 6;
  // op, dst, src1, src2, issue, read, complete, write
  localparam int VEC [6][8] = '{
    '{0,  6, 20, 20,  1,  2,  3,  4},
    '{0,  2, 21, 21,  5,  6,  7,  8},
    '{2,  0,  2,  4,  6,  9, 19, 20},
    '{1,  8,  6,  2,  7,  9, 11, 12},
    '{3, 10,  0,  6,  8, 21, 61, 62},
    '{1,  6,  8,  2, 13, 14, 16, 22}
  };

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [1:0] in_op = 0;
  logic [4:0] in_dst = 0, in_src1 = 0, in_src2 = 0;
  logic in_ready, iss_fire;
  logic [TW-1:0] iss_tag;
  logic [3:0] rd_fire, ex_fire, wr_fire;
  logic [4*TW-1:0] fu_tag;

  int ntests = 0, nfail = 0, wdog = 0;
  int p_op[8], p_dst[8], p_s1[8], p_s2[8];
  int x_is[8], x_rd[8], x_ex[8], x_wr[8];
  int e_is[64], e_rd[64], e_ex[64], e_wr[64], e_un[64];

  scoreboard_ctrl i_scoreboard_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    wdog <= wdog + 1;
    if (wdog > 20000) begin
      nfail++;
      $display("FAIL watchdog: got %0d cycles expected completion", wdog);
      $display("[TB] %0d tests run, %0d failed", ntests + 1, nfail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    ntests++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R8", "in_ready", int'(in_ready), 1);
    chk("R8", "iss_tag", int'(iss_tag), 0);
    chk("R8", "strobes", int'({rd_fire, ex_fire, wr_fire}), 0);
    @(posedge clk); #1;
  endtask

  task automatic drive(input int idx, input int n);
    in_valid = (idx < n);
    if (idx < n) begin
      in_op = 2'(p_op[idx]); in_dst = 5'(p_dst[idx]);
      in_src1 = 5'(p_s1[idx]); in_src2 = 5'(p_s2[idx]);
    end
  endtask

  task automatic run(input int n, input int ncyc);
    int idx = 0;
    for (int i = 0; i < 64; i++) begin
      e_is[i] = 0; e_rd[i] = 0; e_ex[i] = 0; e_wr[i] = 0; e_un[i] = -1;
    end
    drive(idx, n);
    for (int cyc = 1; cyc <= ncyc; cyc++) begin
      @(negedge clk);
      if (iss_fire) e_is[iss_tag] = cyc;
      for (int u = 0; u < 4; u++) begin
        int t = int'(fu_tag[u*TW +: TW]);
        if (rd_fire[u]) begin e_rd[t] = cyc; e_un[t] = u; end
        if (ex_fire[u]) e_ex[t] = cyc;
        if (wr_fire[u]) e_wr[t] = cyc;
      end
      if (in_valid && in_ready) idx++;
      @(posedge clk); #1;
      drive(idx, n);
    end
  endtask

  task automatic compare(input int n);
    for (int i = 0; i < n; i++) begin
      chk("R1", $sformatf("issue cycle of #%0d", i), e_is[i], x_is[i]);
      chk("R4", $sformatf("read cycle of #%0d", i), e_rd[i], x_rd[i]);
      chk("R5", $sformatf("complete cycle of #%0d", i), e_ex[i], x_ex[i]);
      chk("R6", $sformatf("write cycle of #%0d", i), e_wr[i], x_wr[i]);
      chk("R9", $sformatf("unit of #%0d", i), e_un[i], p_op[i]);
    end
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < 6; i++) begin
      p_op[i] = VEC[i][0]; p_dst[i] = VEC[i][1]; p_s1[i] = VEC[i][2]; p_s2[i] = VEC[i][3];
      x_is[i] = VEC[i][4]; x_rd[i] = VEC[i][5]; x_ex[i] = VEC[i][6]; x_wr[i] = VEC[i][7];
    end
    run(6, 75);
    compare(6);
    chk("R2", "second load waits for unit", e_is[1], 5);
    chk("R7", "add write held behind divide read", e_wr[5], 22);
    chk("R4", "divide reads after multiply write", e_rd[4], e_wr[2] + 1);

    do_reset();
    p_op[0]=1; p_dst[0]=1; p_s1[0]=2; p_s2[0]=3; x_is[0]=1;  x_rd[0]=2;  x_ex[0]=4;  x_wr[0]=5;
    p_op[1]=3; p_dst[1]=9; p_s1[1]=1; p_s2[1]=1; x_is[1]=2;  x_rd[1]=6;  x_ex[1]=46; x_wr[1]=47;
    p_op[2]=2; p_dst[2]=1; p_s1[2]=4; p_s2[2]=5; x_is[2]=6;  x_rd[2]=7;  x_ex[2]=17; x_wr[2]=18;
    p_op[3]=0; p_dst[3]=3; p_s1[3]=20; p_s2[3]=20; x_is[3]=7; x_rd[3]=8; x_ex[3]=9;  x_wr[3]=10;
    p_op[4]=0; p_dst[4]=5; p_s1[4]=3; p_s2[4]=3; x_is[4]=11; x_rd[4]=12; x_ex[4]=13; x_wr[4]=14;
    run(5, 55);
    compare(5);
    chk("R3", "same-destination multiply waits for add write", e_is[2], 6);
    chk("R2", "back-to-back load waits for unit", e_is[4], 11);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule